// File: doc/BRIEF.md
# Four-Corner Position and Energy Calculator

This block turns one event from a resistive charge-division readout into a single packed result word. Four 12-bit corner samples arrive together with a one-cycle strobe. Two of them come from the left and right ends of the horizontal divider, and two come from the top and bottom ends of the vertical divider. The block adds all four samples to get the event energy. It reduces that energy to 10 bits and compares it with a threshold supplied by the user. Events that do not clear the threshold are dropped without producing any output.

For an accepted event, the block works out the horizontal position as (left − right)/(left + right) and the vertical position as (top − bottom)/(top + bottom). One shared sequential divider computes both ratios, horizontal first and then vertical. Each ratio is mapped onto an unsigned 10-bit code. The energy, the two position codes and a division-error flag are packed into one 32-bit word, which is offered on a valid/ready handshake. A busy output tells the sampling side when a new strobe would be ignored.

Top module: `corner_event_calc`

## Requirements
- R1: A sample set is captured on a rising edge where `smp_valid` is high and `busy` is low. `busy` is high in the cycle after that edge.
- R2: The energy field `out_word[9:0]` equals bits [13:4] of the 14-bit sum left+right+top+bottom, that is, the sum shifted right by 4.
- R3: An event whose 10-bit energy is less than or equal to `thresh` produces no word, and `busy` is low again one cycle after the capture edge. An energy strictly greater than `thresh` produces a word.
- R4: The horizontal code `out_word[19:10]` equals 512 + q when left ≥ right, and 512 − q otherwise. Here q = (|left − right| · 512) / (left + right), truncated. The result is limited to 1023.
- R5: The vertical code `out_word[29:20]` follows the same rule as R4, using top and bottom.
- R6: If a pair sums to zero, its code is 512 and `out_word[30]` is set. If neither pair sums to zero, `out_word[30]` is clear.
- R7: `out_word[31]` is always zero while `out_valid` is high.
- R8: `out_valid` rises exactly 45 clock edges after the capture edge, whatever the data, including zero denominators.
- R9: A strobe that arrives while `busy` is high is ignored. It does not change the result in progress and does not start another event.
- R10: While `out_valid` is high and `out_ready` is low, `out_word` stays stable and `out_valid` stays high. After an edge where both are high, `out_valid` and `busy` are low.
- R11: While `rst_n` is low, `out_valid` and `busy` are low and `out_word` is zero. This holds even when reset arrives in the middle of a division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a valid corner sample set |
| corner_l | input | 12 | Left end of the horizontal divider |
| corner_r | input | 12 | Right end of the horizontal divider |
| corner_t | input | 12 | Top end of the vertical divider |
| corner_b | input | 12 | Bottom end of the vertical divider |
| thresh | input | 10 | Energy threshold; an event is kept only if its energy is above this value |
| busy | output | 1 | High from capture until the result is handed over or the event is dropped |
| out_valid | output | 1 | Result word is available |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 32 | {0, error, y code, x code, energy} |

## Verification
The hardest case to reach is a zero denominator on one axis while the event still passes the threshold. This needs one pair of corners at zero and enough charge on the other pair to carry the energy above `thresh`. The table includes such events for each axis, and the bench checks that the zeroed axis sits at mid-scale with the error flag set, while the other axis is still divided correctly. A second hard case is a strobe that lands in the middle of a division. The bench pulses `smp_valid` with unrelated corner values halfway through every processed event. It then checks that the word is unchanged and that no second event follows the handshake.

// File: rtl/cec_pkg.sv
// Package: shared types for the four-corner position and energy calculator.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package cec_pkg;

    // Controller states: wait, threshold decision, two divisions, output hold.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_DIVX  = 3'd2,
        ST_DIVY  = 3'd3,
        ST_OUT   = 3'd4
    } cec_state_e;

endpackage

// File: rtl/cec_ratio_prep.sv
// Module: cec_ratio_prep
// Prepares one charge-division ratio for the divider. It produces the
// magnitude of the difference, already shifted by the fraction bits, the
// pair sum used as the denominator, the sign of the difference and a flag
// that is set when the denominator is zero.
// Assumes: the inputs are unsigned conversion results held stable by the caller.
module cec_ratio_prep #(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 9,
    localparam int DEN_W   = SAMPLE_W + 1,
    localparam int NUM_W   = SAMPLE_W + FRAC_W
) (
    input  logic [SAMPLE_W-1:0] pos_i,
    input  logic [SAMPLE_W-1:0] neg_i,
    output logic [NUM_W-1:0]    num_o,
    output logic [DEN_W-1:0]    den_o,
    output logic                negative_o,
    output logic                zero_o
);

    logic [SAMPLE_W-1:0] mag;

    // Pick the magnitude of the difference and record its sign.
    always_comb begin
        negative_o = (neg_i > pos_i);
        mag        = negative_o ? (neg_i - pos_i) : (pos_i - neg_i);
    end

    // Scale the numerator and form the denominator.
    always_comb begin
        num_o  = {mag, {FRAC_W{1'b0}}};
        den_o  = {1'b0, pos_i} + {1'b0, neg_i};
        zero_o = (den_o == '0);
    end

endmodule

// File: rtl/cec_divider.sv
// Module: cec_divider
// Sequential restoring divider that produces one quotient bit per cycle.
// A start pulse loads the operands. NUM_W step cycles follow, then done_o
// pulses for one cycle with the quotient on quo_o. The latency is fixed,
// including for a zero divisor, which yields an all-ones quotient that the
// caller replaces.
// Assumes: start_i is not raised while a division is in progress.
module cec_divider #(
    parameter int NUM_W = 21,
    parameter int DEN_W = 13,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W:0]   diff;

    // One restoring step: shift in the next dividend bit and try to subtract.
    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        fits  = (trial >= {1'b0, den_q});
        diff  = trial - {1'b0, den_q};
    end

    // Iteration registers: load on start, step while the count is nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                den_q <= den_i;
                quo_q <= num_i;
                cnt_q <= CNT_W'(NUM_W);
            end else if (cnt_q != '0) begin
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q;

endmodule

// File: rtl/cec_code_map.sv
// Module: cec_code_map
// Maps a signed ratio, given as a sign and a truncated quotient magnitude
// scaled by 2^(OUT_W-1), onto an unsigned OUT_W-bit code centred at
// mid-scale. The positive end saturates at the largest code. A zero
// denominator forces the mid-scale code.
// Assumes: the magnitude never exceeds mid-scale when the denominator is nonzero.
module cec_code_map #(
    parameter int NUM_W = 21,
    parameter int OUT_W = 10,
    localparam int WIDE_W = NUM_W + 1,
    localparam logic [WIDE_W-1:0] MID  = WIDE_W'(1) << (OUT_W - 1),
    localparam logic [WIDE_W-1:0] MAXC = (WIDE_W'(1) << OUT_W) - WIDE_W'(1)
) (
    input  logic [NUM_W-1:0] quo_i,
    input  logic             negative_i,
    input  logic             zero_i,
    output logic [OUT_W-1:0] code_o
);

    logic [WIDE_W-1:0] up;
    logic [WIDE_W-1:0] mag_lim;
    logic [WIDE_W-1:0] pick;

    // Offset the magnitude around mid-scale, then clamp into the code range.
    always_comb begin
        up      = MID + {1'b0, quo_i};
        mag_lim = ({1'b0, quo_i} > MID) ? MID : {1'b0, quo_i};
        if (zero_i) begin
            pick = MID;
        end else if (negative_i) begin
            pick = MID - mag_lim;
        end else if (up > MAXC) begin
            pick = MAXC;
        end else begin
            pick = up;
        end
        code_o = pick[OUT_W-1:0];
    end

endmodule

// File: rtl/corner_event_calc.sv
// Module: corner_event_calc (top)
// Captures four corner samples on a strobe and forms the 10-bit energy from
// the top bits of their sum. Events that do not clear the threshold are
// dropped. For the rest, one shared divider computes the horizontal ratio
// and then the vertical ratio. The packed word
// {0, div error, y, x, energy} is presented on a valid/ready handshake.
// Assumes: thresh is stable from capture until the following cycle; the
// default widths give a 32-bit word (3*OUT_W + 2).
module corner_event_calc #(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 10,
    localparam int SUM_W   = SAMPLE_W + 2,
    localparam int FRAC_W  = OUT_W - 1,
    localparam int DEN_W   = SAMPLE_W + 1,
    localparam int NUM_W   = SAMPLE_W + FRAC_W,
    localparam int WORD_W  = 3 * OUT_W + 2,
    localparam int AXES    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] corner_l,
    input  logic [SAMPLE_W-1:0] corner_r,
    input  logic [SAMPLE_W-1:0] corner_t,
    input  logic [SAMPLE_W-1:0] corner_b,
    input  logic [OUT_W-1:0]    thresh,
    output logic                busy,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_word
);
    import cec_pkg::*;

    cec_state_e          state_q;
    logic [SAMPLE_W-1:0] pos_q [AXES];
    logic [SAMPLE_W-1:0] neg_q [AXES];
    logic [NUM_W-1:0]    num_ax [AXES];
    logic [DEN_W-1:0]    den_ax [AXES];
    logic                negative_ax [AXES];
    logic                zero_ax [AXES];
    logic [SUM_W-1:0]    full_sum;
    logic [OUT_W-1:0]    energy;
    logic                keep_event;
    logic                div_start;
    logic                div_done;
    logic [NUM_W-1:0]    div_num;
    logic [DEN_W-1:0]    div_den;
    logic [NUM_W-1:0]    div_quo;
    logic                sel_y;
    logic [OUT_W-1:0]    code;
    logic [OUT_W-1:0]    x_code_q;
    logic                x_err_q;
    logic [WORD_W-1:0]   word_q;
    logic                unused_ok;

    // Ratio preparation, one instance per axis.
    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
        cec_ratio_prep #(
            .SAMPLE_W (SAMPLE_W),
            .FRAC_W   (FRAC_W)
        ) u_prep (
            .pos_i      (pos_q[ax]),
            .neg_i      (neg_q[ax]),
            .num_o      (num_ax[ax]),
            .den_o      (den_ax[ax]),
            .negative_o (negative_ax[ax]),
            .zero_o     (zero_ax[ax])
        );
    end

    // Energy: the 14-bit corner sum reduced to its top OUT_W bits.
    always_comb begin
        full_sum   = {1'b0, den_ax[0]} + {1'b0, den_ax[1]};
        energy     = full_sum[SUM_W-1 -: OUT_W];
        keep_event = (energy > thresh);
    end

    assign unused_ok = &{1'b0, full_sum[SUM_W-OUT_W-1:0]};

    // Divider operand selection and start: x from CHECK, y after x completes.
    always_comb begin
        sel_y     = (state_q == ST_DIVX);
        div_num   = sel_y ? num_ax[1] : num_ax[0];
        div_den   = sel_y ? den_ax[1] : den_ax[0];
        div_start = ((state_q == ST_CHECK) && keep_event) ||
                    ((state_q == ST_DIVX) && div_done);
    end

    cec_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    // Code mapping for whichever axis has just finished dividing.
    cec_code_map #(
        .NUM_W (NUM_W),
        .OUT_W (OUT_W)
    ) u_map (
        .quo_i      (div_quo),
        .negative_i ((state_q == ST_DIVY) ? negative_ax[1] : negative_ax[0]),
        .zero_i     ((state_q == ST_DIVY) ? zero_ax[1] : zero_ax[0]),
        .code_o     (code)
    );

    // Event controller: capture, threshold decision, two divisions, output hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pos_q[0] <= '0;
            neg_q[0] <= '0;
            pos_q[1] <= '0;
            neg_q[1] <= '0;
            x_code_q <= '0;
            x_err_q  <= 1'b0;
            word_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (smp_valid) begin
                        pos_q[0] <= corner_l;
                        neg_q[0] <= corner_r;
                        pos_q[1] <= corner_t;
                        neg_q[1] <= corner_b;
                        state_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    state_q <= keep_event ? ST_DIVX : ST_IDLE;
                end
                ST_DIVX: begin
                    if (div_done) begin
                        x_code_q <= code;
                        x_err_q  <= zero_ax[0];
                        state_q  <= ST_DIVY;
                    end
                end
                ST_DIVY: begin
                    if (div_done) begin
                        word_q  <= {1'b0, x_err_q | zero_ax[1], code, x_code_q, energy};
                        state_q <= ST_OUT;
                    end
                end
                ST_OUT: begin
                    if (out_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs derived from the controller state.
    assign busy      = (state_q != ST_IDLE);
    assign out_valid = (state_q == ST_OUT);
    assign out_word  = word_q;

endmodule

// File: rtl/cec_checker.sv
// Module: cec_checker
// Port-level properties of corner_event_calc, attached by bind below.
// Assumes: the default word layout {0, err, y, x, energy}.
module cec_checker #(
    parameter int OUT_W = 10,
    localparam int WORD_W = 3 * OUT_W + 2,
    localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic              busy,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word
);

    // R1: an accepted strobe makes the block busy on the next cycle.
    a_r1_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !busy) |=> busy);

    // R7: the reserved top bit is zero in every offered word.
    a_r7_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_word[WORD_W-1]);

    // R6: the error flag only comes with at least one mid-scale coordinate.
    a_r6_err_means_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[WORD_W-2]) |->
        ((out_word[2*OUT_W-1:OUT_W] == MID) || (out_word[3*OUT_W-1:2*OUT_W] == MID)));

    // R10: a stalled word stays offered and unchanged.
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R10: a completed handshake leaves the block idle.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && !busy));

    // R9: a pending word keeps the input side blocked.
    a_r9_valid_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

endmodule

bind corner_event_calc cec_checker #(.OUT_W(OUT_W)) u_cec_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
);

// File: tb/corner_event_calc_bench.sv
// Bench for corner_event_calc: a vector table walked by one loop, then
// directed tests for threshold edges, dropped events and reset mid-event.
module corner_event_calc_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 45;
    localparam int NVEC       = 9;

    // {left, right, top, bottom, thresh}
    localparam logic [57:0] VEC [NVEC] = '{
        {12'd1000, 12'd1000, 12'd1000, 12'd1000, 10'd0},
        {12'd4095, 12'd0,    12'd4095, 12'd0,    10'd100},
        {12'd0,    12'd4095, 12'd0,    12'd4095, 10'd100},
        {12'd3000, 12'd1000, 12'd500,  12'd1500, 10'd10},
        {12'd7,    12'd3,    12'd100,  12'd1,    10'd0},
        {12'd0,    12'd0,    12'd2000, 12'd1000, 10'd50},
        {12'd2000, 12'd1000, 12'd0,    12'd0,    10'd50},
        {12'd123,  12'd4000, 12'd2222, 12'd2221, 10'd200},
        {12'd1,    12'd2,    12'd4095, 12'd4094, 10'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] corner_l = '0;
    logic [11:0] corner_r = '0;
    logic [11:0] corner_t = '0;
    logic [11:0] corner_b = '0;
    logic [9:0]  thresh = '0;
    logic        busy;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    corner_event_calc u_corner_event_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .corner_l  (corner_l),
        .corner_r  (corner_r),
        .corner_t  (corner_t),
        .corner_b  (corner_b),
        .thresh    (thresh),
        .busy      (busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference code for one axis, from R4/R5/R6.
    function automatic logic [9:0] ref_code(input int p, input int n);
        int s;
        int q;
        s = p + n;
        if (s == 0) return 10'd512;
        if (p >= n) begin
            q = 512 + ((p - n) * 512) / s;
            if (q > 1023) q = 1023;
        end else begin
            q = 512 - ((n - p) * 512) / s;
        end
        return q[9:0];
    endfunction

    function automatic logic [31:0] ref_word(input int l, input int r, input int t, input int b);
        int e;
        logic err;
        e   = (l + r + t + b) >> 4;
        err = ((l + r) == 0) || ((t + b) == 0);
        return {1'b0, err, ref_code(t, b), ref_code(l, r), e[9:0]};
    endfunction

    // Drive one event; check capture, latency, word, hold, handshake or drop.
    task automatic run_event(input logic [11:0] l, input logic [11:0] r,
                             input logic [11:0] t, input logic [11:0] b,
                             input logic [9:0] thr, input bit expect_word);
        logic [31:0] exp;
        logic [31:0] first;
        int n;
        exp = ref_word(int'(l), int'(r), int'(t), int'(b));
        @(negedge clk);
        corner_l = l; corner_r = r; corner_t = t; corner_b = b;
        thresh = thr; smp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        chk(busy === 1'b1, "R1 busy after capture", 32'(busy), 32'd1);
        if (!expect_word) begin
            @(posedge clk);
            @(negedge clk);
            chk(busy === 1'b0 && out_valid === 1'b0, "R3 dropped event",
                {30'd0, busy, out_valid}, 32'd0);
            return;
        end
        n = 0;
        while (out_valid !== 1'b1 && n < 200) begin
            @(posedge clk);
            n = n + 1;
            @(negedge clk);
            if (n == 10) begin
                // R9: strobe with unrelated data during the division
                smp_valid = 1'b1;
                corner_l = 12'hABC; corner_r = 12'h123; corner_t = 12'h456; corner_b = 12'h789;
            end else if (n == 11) begin
                smp_valid = 1'b0;
            end
        end
        chk(n == LATENCY, "R8 latency", 32'(n), 32'(LATENCY));
        chk(out_word[9:0] == exp[9:0], "R2 energy", 32'(out_word[9:0]), 32'(exp[9:0]));
        chk(out_word[19:10] == exp[19:10], "R4 x code", 32'(out_word[19:10]), 32'(exp[19:10]));
        chk(out_word[29:20] == exp[29:20], "R5 y code", 32'(out_word[29:20]), 32'(exp[29:20]));
        chk(out_word[30] == exp[30], "R6 error bit", 32'(out_word[30]), 32'(exp[30]));
        chk(out_word[31] == 1'b0, "R7 top bit", 32'(out_word[31]), 32'd0);
        first = out_word;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(out_valid === 1'b1 && out_word === first, "R10 hold", out_word, first);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid === 1'b0 && busy === 1'b0, "R10 release",
            {30'd0, busy, out_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0 && out_valid === 1'b0, "R9 no queued event",
            {30'd0, busy, out_valid}, 32'd0);
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0, "R11 busy in reset", 32'(busy), 32'd0);
        chk(out_valid === 1'b0, "R11 valid in reset", 32'(out_valid), 32'd0);
        chk(out_word === 32'd0, "R11 word in reset", out_word, 32'd0);
        rst_n = 1'b1;

        // Table walk: every entry clears its threshold.
        for (int i = 0; i < NVEC; i++) begin
            run_event(VEC[i][57:46], VEC[i][45:34], VEC[i][33:22], VEC[i][21:10],
                      VEC[i][9:0], 1'b1);
        end

        // R3: energy 375 against thresholds 375 (drop) and 374 (keep)
        run_event(12'd3000, 12'd1000, 12'd500, 12'd1500, 10'd375, 1'b0);
        run_event(12'd3000, 12'd1000, 12'd500, 12'd1500, 10'd374, 1'b1);
        // R3: all-zero event never clears even a zero threshold
        run_event(12'd0, 12'd0, 12'd0, 12'd0, 10'd0, 1'b0);
        // R3: small sum whose top bits are zero
        run_event(12'd5, 12'd5, 12'd2, 12'd3, 10'd0, 1'b0);

        // R11: reset in the middle of a division
        @(negedge clk);
        corner_l = 12'd900; corner_r = 12'd100; corner_t = 12'd800; corner_b = 12'd200;
        thresh = 10'd0; smp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0 && out_valid === 1'b0 && out_word === 32'd0,
            "R11 reset mid-event", {busy, out_valid, out_word[29:0]}, 32'd0);
        rst_n = 1'b1;

        // After reset, a fresh event still works.
        run_event(12'd2500, 12'd500, 12'd1000, 12'd3000, 10'd1, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule